// File: doc/BRIEF.md
# Wide Multiply-Accumulate Sequencer on a Two-Read-Port Register File

This block runs one instruction: the register pair named as the accumulator is replaced by its old double-width value plus the full product of two source registers. The register file it works against has only two read ports. The unit therefore reads the two multiplicands in the issue cycle, which lets the product start at once. It reads the accumulator pair one cycle later through the same two ports. The accumulator is needed only when the product is ready, so this second read costs no extra latency.

The unit contains the register file, a small sequencer that steers the two read addresses, a three-register multiply-add pipeline and the writeback of the double-width sum as two registers. The `DUAL_WB` parameter picks the writeback variant. The dual variant writes both halves in one cycle on two write ports. The sequential variant writes the low half and then the high half on one port in two consecutive cycles. An external write port lets neighbouring logic fill the register file between instructions.

Top module: `wmac_unit`

## Requirements
- R1: Four 5-bit register specifiers are taken from the 32-bit instruction: accumulator-high at bits [24:20], accumulator-low at [19:15], source 1 at [14:10] and source 2 at [9:5]. Bits [31:25] and [4:0] have no effect.
- R2: The result written back equals ({hi,lo} + src1*src2) modulo 2^(2W), where src1 and src2 are unsigned and the product is the full 2W-bit product.
- R3: The source registers are sampled in the issue cycle. The accumulator pair is read in the following cycle, so an external write committed at the issue edge is seen by the accumulator read but not by the source read.
- R4: With DUAL_WB=1, both halves are written in the third cycle after the issue cycle, the low half on port 0 and the high half on port 1. Busy is low in the next cycle.
- R5: With DUAL_WB=0, only port 0 writes. It writes the low half in the third cycle after issue and the high half in the fourth. wb_we[1] stays low.
- R6: When the hi and lo specifiers name the same register, that register afterwards holds the high half.
- R7: Busy is low after reset. It is high from the cycle after issue until the last writeback cycle, inclusive. A go asserted while busy is high is ignored.
- R8: Register 0 always reads as zero. Writes to it from either the external port or writeback have no effect.
- R9: An external write (ext_we high while busy is low) commits at the next clock edge and is seen by later reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Issue request, accepted when busy is low |
| instr | input | 32 | Instruction carrying the four specifiers |
| busy | output | 1 | Instruction in flight |
| ext_we | input | 1 | External register write enable |
| ext_addr | input | 5 | External write register number |
| ext_data | input | W | External write data |
| wb_we | output | 2 | Writeback enables for port 0 and port 1 |
| wb_addr0 | output | 5 | Port 0 writeback register |
| wb_data0 | output | W | Port 0 writeback data |
| wb_addr1 | output | 5 | Port 1 writeback register |
| wb_data1 | output | W | Port 1 writeback data |

## Verification
The assertions assume that external writes are raised only while busy is low. The bench keeps to this by driving the external port only when both units are idle, or in the issue cycle itself. A go raised while busy is high is not an assumption: it is driven on purpose to show that it is dropped. The bench computes expected sums from its own register model, and it tags each expected writeback with the cycle in which it must appear.

// File: rtl/wmac_pkg.sv
package wmac_pkg;
   localparam int SPEC_W  = 5;
   localparam int NREG    = 1 << SPEC_W;
   localparam int HI_LSB  = 20;
   localparam int LO_LSB  = 15;
   localparam int S1_LSB  = 10;
   localparam int S2_LSB  = 5;
   localparam int INSTR_W = 32;

   typedef logic [SPEC_W-1:0] spec_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACCRD,
      ST_MUL,
      ST_WB,
      ST_WB_HI
   } seq_state_e;
endpackage

// File: rtl/wmac_regfile.sv
module wmac_regfile
   import wmac_pkg::*;
#(
   parameter int W   = 32,
   parameter int NWP = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  spec_t                     ra_a,
   input  spec_t                     ra_b,
   output logic [W-1:0]              rd_a,
   output logic [W-1:0]              rd_b,
   input  logic [NWP-1:0]            we,
   input  logic [NWP-1:0][SPEC_W-1:0] wa,
   input  logic [NWP-1:0][W-1:0]     wd
);
   logic [W-1:0] rf [NREG];

   generate
      if (NWP < 1) begin : g_bad_nwp
         $error("wmac_regfile: NWP must be at least 1");
      end
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         if (i == 0) begin : g_zero
            assign rf[i] = '0;
         end else begin : g_live
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  q <= '0;
               end else begin
                  // higher port index wins on a shared address
                  for (int p = 0; p < NWP; p++) begin
                     if (we[p] && wa[p] == SPEC_W'(i)) q <= wd[p];
                  end
               end
            end
            assign rf[i] = q;
         end
      end
   endgenerate

   assign rd_a = rf[ra_a];
   assign rd_b = rf[ra_b];

   AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ra_a == '0) |-> (rd_a == '0)); // R8
endmodule

// File: rtl/wmac_mulpipe.sv
module wmac_mulpipe #(
   parameter int W = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld_src,
   input  logic           ld_acc,
   input  logic           ld_sum,
   input  logic [W-1:0]   src_a,
   input  logic [W-1:0]   src_b,
   input  logic [2*W-1:0] acc_in,
   output logic [2*W-1:0] sum
);
   localparam int DW = 2 * W;

   logic [W-1:0]  op_a, op_b;
   logic [DW-1:0] prod_q, acc_q;

   // stage 1: operands, stage 2: product, stage 3: accumulated sum
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_a   <= '0;
         op_b   <= '0;
         prod_q <= '0;
         acc_q  <= '0;
         sum    <= '0;
      end else begin
         if (ld_src) begin
            op_a <= src_a;
            op_b <= src_b;
         end
         if (ld_acc) begin
            prod_q <= DW'(op_a) * DW'(op_b);
            acc_q  <= acc_in;
         end
         if (ld_sum) sum <= prod_q + acc_q;
      end
   end

   AST_SUM_AFTER_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      ld_acc |=> !ld_acc); // R3
endmodule

// File: rtl/wmac_ctrl.sv
module wmac_ctrl
   import wmac_pkg::*;
#(
   parameter bit DUAL_WB = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [INSTR_W-1:0] instr,
   input  logic               ext_we,
   output logic               busy,
   output spec_t              ra_a,
   output spec_t              ra_b,
   output logic               ld_src,
   output logic               ld_acc,
   output logic               ld_sum,
   output logic [1:0]         wb_we,
   output spec_t              wb_addr0,
   output spec_t              wb_addr1,
   output logic               sel_hi0
);
   seq_state_e state, state_nx;
   spec_t      hi_q, lo_q;
   logic       issue;
   logic       unused_fields;

   assign unused_fields = ^{instr[INSTR_W-1:HI_LSB+SPEC_W], instr[S2_LSB-1:0]};

   assign busy  = (state != ST_IDLE);
   assign issue = go && !busy;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:  if (go) state_nx = ST_ACCRD;
         ST_ACCRD: state_nx = ST_MUL;
         ST_MUL:   state_nx = ST_WB;
         ST_WB:    state_nx = DUAL_WB ? ST_IDLE : ST_WB_HI;
         ST_WB_HI: state_nx = ST_IDLE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         hi_q  <= '0;
         lo_q  <= '0;
      end else begin
         state <= state_nx;
         if (issue) begin
            hi_q <= instr[HI_LSB +: SPEC_W];
            lo_q <= instr[LO_LSB +: SPEC_W];
         end
      end
   end

   // same two ports: sources while idle, accumulator pair one cycle later
   assign ra_a   = (state == ST_ACCRD) ? hi_q : instr[S1_LSB +: SPEC_W];
   assign ra_b   = (state == ST_ACCRD) ? lo_q : instr[S2_LSB +: SPEC_W];
   assign ld_src = issue;
   assign ld_acc = (state == ST_ACCRD);
   assign ld_sum = (state == ST_MUL);

   generate
      if (DUAL_WB) begin : g_dual
         assign wb_we    = {state == ST_WB, state == ST_WB};
         assign wb_addr0 = lo_q;
         assign wb_addr1 = hi_q;
         assign sel_hi0  = 1'b0;

         AST_DUAL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
            wb_we[0] |=> !busy); // R4
      end else begin : g_seq
         assign wb_we    = {1'b0, (state == ST_WB) || (state == ST_WB_HI)};
         assign wb_addr0 = (state == ST_WB_HI) ? hi_q : lo_q;
         assign wb_addr1 = hi_q;
         assign sel_hi0  = (state == ST_WB_HI);

         AST_SEQ_HI_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            (wb_we[0] && !sel_hi0) |=> (wb_we[0] && sel_hi0)); // R5
      end
   endgenerate

   AST_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !busy) |=> busy); // R7
   AST_WB_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(go && !busy, 3) |-> wb_we[0]); // R4
   AST_EXT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ext_we |-> !busy); // R9
endmodule

// File: rtl/wmac_unit.sv
module wmac_unit
   import wmac_pkg::*;
#(
   parameter int W       = 32,
   parameter bit DUAL_WB = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [INSTR_W-1:0] instr,
   output logic               busy,
   input  logic               ext_we,
   input  logic [SPEC_W-1:0]  ext_addr,
   input  logic [W-1:0]       ext_data,
   output logic [1:0]         wb_we,
   output logic [SPEC_W-1:0]  wb_addr0,
   output logic [W-1:0]       wb_data0,
   output logic [SPEC_W-1:0]  wb_addr1,
   output logic [W-1:0]       wb_data1
);
   localparam int DW  = 2 * W;
   localparam int NWP = 3;

   generate
      if (W < 2 || W > 64) begin : g_bad_w
         $error("wmac_unit: W must lie in 2..64");
      end
   endgenerate

   spec_t          ra_a, ra_b;
   logic [W-1:0]   rd_a, rd_b;
   logic           ld_src, ld_acc, ld_sum, sel_hi0;
   logic [DW-1:0]  sum;

   wmac_ctrl #(.DUAL_WB(DUAL_WB)) u_ctrl (
      .clk, .rst_n, .go, .instr, .ext_we, .busy,
      .ra_a, .ra_b, .ld_src, .ld_acc, .ld_sum,
      .wb_we, .wb_addr0, .wb_addr1, .sel_hi0
   );

   wmac_mulpipe #(.W(W)) u_pipe (
      .clk, .rst_n, .ld_src, .ld_acc, .ld_sum,
      .src_a (rd_a),
      .src_b (rd_b),
      .acc_in({rd_a, rd_b}),
      .sum
   );

   assign wb_data0 = sel_hi0 ? sum[DW-1:W] : sum[W-1:0];
   assign wb_data1 = sum[DW-1:W];

   wmac_regfile #(.W(W), .NWP(NWP)) u_rf (
      .clk, .rst_n, .ra_a, .ra_b, .rd_a, .rd_b,
      .we({wb_we[1], wb_we[0], ext_we}),
      .wa({wb_addr1, wb_addr0, ext_addr}),
      .wd({wb_data1, wb_data0, ext_data})
   );
endmodule

// File: tb/wmac_unit_bench.sv
module wmac_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   typedef struct {
      logic [4:0]   addr;
      logic [W-1:0] data;
      int           cyc;
   } wb_item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic go = 1'b0;
   logic [31:0] instr = '0;
   logic ext_we = 1'b0;
   logic [4:0] ext_addr = '0;
   logic [W-1:0] ext_data = '0;

   logic busy_d, busy_s;
   logic [1:0] we_d, we_s;
   logic [4:0] a0_d, a1_d, a0_s, a1_s;
   logic [W-1:0] d0_d, d1_d, d0_s, d1_s;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   logic [W-1:0] model [32];
   wb_item_t q_d[$];
   wb_item_t q_s[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wmac_unit #(.W(W), .DUAL_WB(1'b1)) u_wmac_unit (
      .clk, .rst_n, .go, .instr, .busy(busy_d), .ext_we, .ext_addr, .ext_data,
      .wb_we(we_d), .wb_addr0(a0_d), .wb_data0(d0_d), .wb_addr1(a1_d), .wb_data1(d1_d));

   wmac_unit #(.W(W), .DUAL_WB(1'b0)) u_wmac_unit_seq (
      .clk, .rst_n, .go, .instr, .busy(busy_s), .ext_we, .ext_addr, .ext_data,
      .wb_we(we_s), .wb_addr0(a0_s), .wb_data0(d0_s), .wb_addr1(a1_s), .wb_data1(d1_s));

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic match(input string tag, inout wb_item_t q[$], input logic [4:0] addr, input logic [W-1:0] data);
      wb_item_t it;
      if (q.size() == 0) begin
         chk(1'b0, {tag, " unexpected write R7"}, {59'd0, addr}, 64'd0);
      end else begin
         it = q.pop_front();
         chk(addr == it.addr, {tag, " addr R1"}, addr, it.addr);
         chk(data == it.data, {tag, " data R2"}, data, it.data);
         chk(cyc == it.cyc, {tag, " cycle R4/R5"}, cyc, it.cyc);
      end
   endtask

   // monitor: samples a quarter period after the falling edge
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_PERIOD/4);
         if (rst_n) begin
            if (we_d[0]) match("dual p0", q_d, a0_d, d0_d);
            if (we_d[1]) match("dual p1", q_d, a1_d, d1_d);
            if (we_s[0]) match("seq p0", q_s, a0_s, d0_s);
            if (we_s[1]) chk(1'b0, "seq port1 idle R5", 64'd1, 64'd0);
         end
      end
   end

   function automatic logic [31:0] mk(input int hi, input int lo, input int s1, input int s2, input logic [11:0] junk);
      return {junk[6:0], 5'(hi), 5'(lo), 5'(s1), 5'(s2), junk[11:7]};
   endfunction

   task automatic ext_write(input int addr, input logic [W-1:0] data);
      @(negedge clk);
      ext_we = 1'b1; ext_addr = 5'(addr); ext_data = data;
      if (addr != 0) model[addr] = data;
      @(negedge clk);
      ext_we = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy_d || busy_s) @(negedge clk);
   endtask

   // issue one MAC; optional external write in the issue cycle, optional go while busy
   task automatic do_mac(input int hi, input int lo, input int s1, input int s2,
                         input bit with_ext, input int eaddr, input logic [W-1:0] edata,
                         input bit poke_busy);
      logic [W-1:0] a, b;
      logic [63:0] acc, sum;
      int c;
      wb_item_t it;
      wait_idle();
      @(negedge clk);
      c = cyc;
      go = 1'b1;
      instr = mk(hi, lo, s1, s2, 12'hA5C);
      a = model[s1];
      b = model[s2];
      if (with_ext) begin
         ext_we = 1'b1; ext_addr = 5'(eaddr); ext_data = edata;
         if (eaddr != 0) model[eaddr] = edata;
      end
      acc = {model[hi], model[lo]};
      sum = acc + {32'd0, a} * {32'd0, b};
      it.addr = 5'(lo); it.data = sum[31:0];  it.cyc = c + 3; q_d.push_back(it); q_s.push_back(it);
      it.addr = 5'(hi); it.data = sum[63:32]; it.cyc = c + 3; q_d.push_back(it);
      it.cyc = c + 4; q_s.push_back(it);
      if (lo != 0) model[lo] = sum[31:0];
      if (hi != 0) model[hi] = sum[63:32];
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         ext_we = 1'b0;
         go = poke_busy && (k <= 2);
         instr = mk(7, 8, 1, 2, 12'h000);
         chk(busy_d == (k <= 3), "dual busy window R7", busy_d, (k <= 3));
         chk(busy_s == (k <= 4), "seq busy window R7", busy_s, (k <= 4));
      end
      go = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 32; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      chk(busy_d == 1'b0 && busy_s == 1'b0, "reset busy low R7", {busy_d, busy_s}, 0);
      chk(we_d == 2'b00 && we_s == 2'b00, "reset no write R7", {we_d, we_s}, 0);
      rst_n = 1'b1;
      ext_write(1, 32'd7);
      ext_write(2, 32'd9);
      ext_write(3, 32'd100);
      ext_write(4, 32'h8000_0001);
      ext_write(10, 32'hFFFF_FFFF);
      ext_write(11, 32'hFFFF_FFFF);
      ext_write(12, 32'hFFFF_FFFF);
      ext_write(13, 32'hFFFF_FFFF);
      ext_write(0, 32'd55);                          // R8 ignored
      do_mac(3, 4, 1, 2, 1'b0, 0, '0, 1'b0);         // R2 basic, R9 loaded values
      do_mac(12, 13, 10, 11, 1'b0, 0, '0, 1'b0);     // R2 wrap modulo 2^64
      do_mac(5, 5, 1, 4, 1'b0, 0, '0, 1'b0);         // R6 same register
      do_mac(6, 5, 0, 5, 1'b0, 0, '0, 1'b0);         // R6 reads hi half back, R8 src zero
      do_mac(0, 8, 10, 2, 1'b0, 0, '0, 1'b0);        // R8 write to r0 dropped
      do_mac(9, 0, 1, 2, 1'b0, 0, '0, 1'b0);         // R8 acc lo reads zero
      do_mac(3, 4, 3, 4, 1'b0, 0, '0, 1'b1);         // R7 go while busy ignored, chained
      do_mac(14, 15, 14, 2, 1'b1, 14, 32'd1234, 1'b0); // R3 ext at issue: acc new, src old
      do_mac(14, 9, 14, 14, 1'b0, 0, '0, 1'b0);      // R9 ext value visible later
      wait_idle();
      repeat (4) @(negedge clk);
      chk(q_d.size() == 0, "dual queue drained R4", q_d.size(), 0);
      chk(q_s.size() == 0, "seq queue drained R5", q_s.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      total++;
      bad++;
      $display("FAIL watchdog expired R7 act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule